// File: doc/BRIEF.md
# Soft-Error Report Queue

This block sits between a configuration-memory checker and the host. Each soft-error report names a sector, says whether the upset can be corrected, and gives a bit location. Accepted reports become messages in a queue. The host drains the queue through a valid/ready read port. An active-high error pin tells the host that messages are waiting. A message stays queued until the host reads it, even when the fault was repaired long before.

Each sector carries its own state: a detection-enable bit, a hold bit used while the sector is reloaded, and a re-announce timer for uncorrectable upsets. When scrubbing is on, a correctable report raises a one-cycle correction request for its sector. When scrubbing is off, the first accepted report from a sector turns off detection for that sector. A reload-complete strobe restores detection, releases the hold and stops any re-announcing for that sector.

The pin is driven by a three-state machine:

- `PIN_IDLE`: the queue is empty and the pin is low.
- `PIN_ACTIVE`: the pin is high.
- `PIN_GAP`: a one-cycle low pulse.

The transitions are:

- IDLE→ACTIVE on an insertion.
- ACTIVE→GAP on an insertion.
- ACTIVE→IDLE when a read empties the queue.
- GAP→ACTIVE if the queue is non-empty on the next cycle.
- GAP→IDLE otherwise.

Top module: `softerr_report_queue`

## Requirements
- R1: After reset the queue is empty (rd_valid low), and err_pin, ovf_flag and fix_req are all low.
- R2: An accepted report is visible on the rd_* port in the cycle after it is presented, with rd_repeat=0. Messages leave the queue in arrival order, and only on a cycle with rd_valid and rd_ready both high. The head is held unchanged until that read, whatever the scrubbing setting.
- R3: When scrub_en=1, an accepted report with rpt_uncorr=0 produces fix_req=1 for exactly one cycle, in the cycle after the report, with fix_sector equal to the reported sector. When scrub_en=0, fix_req stays low.
- R4: When scrub_en=0, the first accepted report from a sector disables that sector. Its later reports, correctable or not, are ignored until reload_done for that sector.
- R5: An accepted report with rpt_uncorr=1 starts a per-sector timer. With reinsert_period=P>0, a copy appears with rd_repeat=1, rd_uncorr=1 and the same sector and location. It is first visible P+1 cycles after the original became visible, and a further copy follows every P cycles. P=0 disables re-insertion.
- R6: A reload_done pulse for a sector stops further copies for that sector and re-enables its detection.
- R7: A hold_req pulse for a sector masks its reports, which are neither queued nor produce fix_req, until a reload_done pulse for that sector. If both arrive in the same cycle, hold_req wins.
- R8: err_pin goes high in the cycle after an insertion into an empty queue and stays high while the queue is non-empty. It goes low in the cycle after a read empties the queue.
- R9: An insertion while err_pin is high drives err_pin low for exactly one cycle, after which it is high again.
- R10: The queue holds DEPTH messages. A message offered while the queue is full is dropped and sets ovf_flag. ovf_flag clears on the next read, unless a new drop happens in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scrub_en | input | 1 | Automatic correction enabled |
| reinsert_period | input | PER_W | Re-announce period in cycles, 0 = off |
| rpt_valid | input | 1 | Report strobe from the checker |
| rpt_sector | input | SECT_W | Reported sector |
| rpt_uncorr | input | 1 | 1 = uncorrectable upset |
| rpt_loc | input | LOC_W | Bit location of the upset |
| hold_req | input | N_SECTORS | Per-sector reload-start pulse |
| reload_done | input | N_SECTORS | Per-sector reload-complete pulse |
| rd_ready | input | 1 | Host accepts the head message |
| rd_valid | output | 1 | Head message present |
| rd_sector | output | SECT_W | Head sector |
| rd_uncorr | output | 1 | Head uncorrectable flag |
| rd_repeat | output | 1 | Head is a periodic copy |
| rd_loc | output | LOC_W | Head bit location |
| ovf_flag | output | 1 | Sticky drop indicator |
| err_pin | output | 1 | Active error pin |
| fix_req | output | 1 | Correction request pulse |
| fix_sector | output | SECT_W | Sector to correct |

## Verification
Results appear at fixed delays:

- The queue head, fix_req and the pin respond one clock edge after a report.
- The pin drops one edge after the emptying read.
- A periodic copy lands P+1 edges after the edge that queued the original, and every P edges after that.

The bench drives inputs and samples outputs on the falling edge. It counts rising edges from the stimulus to the exact edge where each result is due. It also samples one edge early, where the result must still be absent, so that a late or early result is caught as well as a wrong one.

// File: rtl/softerr_pkg.sv
package softerr_pkg;
    typedef enum logic [1:0] {
        PIN_IDLE   = 2'd0,
        PIN_ACTIVE = 2'd1,
        PIN_GAP    = 2'd2
    } pin_state_t;
endpackage

// File: rtl/softerr_fifo.sv
module softerr_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [W-1:0]               push_data,
    input  logic                       pop,
    output logic [W-1:0]               head,
    output logic                       valid,
    output logic                       full,
    output logic                       ins,
    output logic                       nz_next,
    output logic [$clog2(DEPTH+1)-1:0] level,
    output logic                       ovf
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          pop_ok;
    logic [CW-1:0] level_nx;

    assign valid  = (level != '0);
    assign full   = (level == CW'(DEPTH));
    assign ins    = push && !full;
    assign pop_ok = pop && valid;
    assign head   = mem[rd_ptr];

    always_comb begin
        level_nx = level;
        if (ins && !pop_ok)      level_nx = level + 1'b1;
        else if (!ins && pop_ok) level_nx = level - 1'b1;
    end
    assign nz_next = (level_nx != '0);

    always_ff @(posedge clk) begin
        if (ins) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
            ovf    <= 1'b0;
        end else begin
            level <= level_nx;
            if (ins)    wr_ptr <= wr_ptr + 1'b1;
            if (pop_ok) rd_ptr <= rd_ptr + 1'b1;
            if (push && full) ovf <= 1'b1;
            else if (pop_ok)  ovf <= 1'b0;
        end
    end
endmodule

// File: rtl/softerr_sector_slot.sv
module softerr_sector_slot #(
    parameter int LOC_W = 12,
    parameter int PER_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scrub_en,
    input  logic [PER_W-1:0] period,
    input  logic             rpt_hit,
    input  logic             rpt_uncorr,
    input  logic [LOC_W-1:0] rpt_loc,
    input  logic             hold_req,
    input  logic             reload_done,
    input  logic             grant,
    output logic             accept,
    output logic             pend,
    output logic [LOC_W-1:0] uc_loc
);
    logic             det_en;
    logic             held;
    logic             uc_active;
    logic [PER_W-1:0] timer;

    assign accept = rpt_hit && det_en && !held;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            det_en    <= 1'b1;
            held      <= 1'b0;
            uc_active <= 1'b0;
            timer     <= '0;
            pend      <= 1'b0;
            uc_loc    <= '0;
        end else begin
            if (hold_req)         held <= 1'b1;
            else if (reload_done) held <= 1'b0;

            if (reload_done)                det_en <= 1'b1;
            else if (accept && !scrub_en)   det_en <= 1'b0;

            if (reload_done) begin
                uc_active <= 1'b0;
                timer     <= '0;
                pend      <= 1'b0;
            end else begin
                if (grant) pend <= 1'b0;
                if (accept && rpt_uncorr) begin
                    uc_active <= 1'b1;
                    uc_loc    <= rpt_loc;
                    timer     <= '0;
                end else if (uc_active && period != '0) begin
                    if (timer >= period - 1'b1) begin
                        timer <= '0;
                        pend  <= 1'b1;
                    end else begin
                        timer <= timer + 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/softerr_pin_fsm.sv
module softerr_pin_fsm
    import softerr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ins,
    input  logic nz_next,
    output logic pin
);
    pin_state_t state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= PIN_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            PIN_IDLE:   if (ins) state_nx = PIN_ACTIVE;
            PIN_ACTIVE: begin
                if (ins)           state_nx = PIN_GAP;
                else if (!nz_next) state_nx = PIN_IDLE;
            end
            PIN_GAP:    state_nx = nz_next ? PIN_ACTIVE : PIN_IDLE;
            default:    state_nx = PIN_IDLE;
        endcase
    end

    always_comb begin
        pin = (state == PIN_ACTIVE);
    end
endmodule

// File: rtl/softerr_report_queue.sv
module softerr_report_queue #(
    parameter int N_SECTORS = 8,
    parameter int LOC_W     = 12,
    parameter int PER_W     = 12,
    parameter int DEPTH     = 16,
    localparam int SECT_W   = $clog2(N_SECTORS),
    localparam int MSG_W    = 2 + SECT_W + LOC_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 scrub_en,
    input  logic [PER_W-1:0]     reinsert_period,
    input  logic                 rpt_valid,
    input  logic [SECT_W-1:0]    rpt_sector,
    input  logic                 rpt_uncorr,
    input  logic [LOC_W-1:0]     rpt_loc,
    input  logic [N_SECTORS-1:0] hold_req,
    input  logic [N_SECTORS-1:0] reload_done,
    input  logic                 rd_ready,
    output logic                 rd_valid,
    output logic [SECT_W-1:0]    rd_sector,
    output logic                 rd_uncorr,
    output logic                 rd_repeat,
    output logic [LOC_W-1:0]     rd_loc,
    output logic                 ovf_flag,
    output logic                 err_pin,
    output logic                 fix_req,
    output logic [SECT_W-1:0]    fix_sector
);
    localparam int CW = $clog2(DEPTH+1);

    logic [N_SECTORS-1:0] rpt_hit, accept, pend, grant;
    logic [LOC_W-1:0]     uc_loc [N_SECTORS];
    logic                 new_push, rein_any, push_req;
    logic [SECT_W-1:0]    rein_sel;
    logic [MSG_W-1:0]     push_data, head;
    logic                 fifo_full, ins, nz_next;
    logic [CW-1:0]        level;

    for (genvar g = 0; g < N_SECTORS; g++) begin : g_slot
        assign rpt_hit[g] = rpt_valid && (rpt_sector == SECT_W'(g));
        softerr_sector_slot #(.LOC_W(LOC_W), .PER_W(PER_W)) u_slot (
            .clk(clk), .rst_n(rst_n), .scrub_en(scrub_en),
            .period(reinsert_period), .rpt_hit(rpt_hit[g]),
            .rpt_uncorr(rpt_uncorr), .rpt_loc(rpt_loc),
            .hold_req(hold_req[g]), .reload_done(reload_done[g]),
            .grant(grant[g]), .accept(accept[g]), .pend(pend[g]),
            .uc_loc(uc_loc[g])
        );
    end

    assign new_push = |accept;

    // fresh reports win; pending copies served lowest sector first
    always_comb begin
        grant    = '0;
        rein_sel = '0;
        rein_any = 1'b0;
        if (!new_push) begin
            for (int i = 0; i < N_SECTORS; i++) begin
                if (pend[i] && !rein_any) begin
                    rein_any = 1'b1;
                    grant[i] = 1'b1;
                    rein_sel = SECT_W'(i);
                end
            end
        end
    end

    assign push_req  = new_push || rein_any;
    assign push_data = new_push ? {1'b0, rpt_uncorr, rpt_sector, rpt_loc}
                                : {1'b1, 1'b1, rein_sel, uc_loc[rein_sel]};

    softerr_fifo #(.W(MSG_W), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push_req), .push_data(push_data),
        .pop(rd_ready), .head(head), .valid(rd_valid), .full(fifo_full),
        .ins(ins), .nz_next(nz_next), .level(level), .ovf(ovf_flag)
    );

    assign {rd_repeat, rd_uncorr, rd_sector, rd_loc} = head;

    softerr_pin_fsm u_pin (
        .clk(clk), .rst_n(rst_n), .ins(ins), .nz_next(nz_next), .pin(err_pin)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fix_req    <= 1'b0;
            fix_sector <= '0;
        end else begin
            fix_req    <= new_push && scrub_en && !rpt_uncorr;
            fix_sector <= rpt_sector;
        end
    end
endmodule

// File: rtl/softerr_report_queue_chk.sv
module softerr_report_queue_chk #(
    parameter int DEPTH  = 16,
    parameter int SECT_W = 3,
    parameter int LOC_W  = 12
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       err_pin,
    input logic                       rd_valid,
    input logic                       rd_ready,
    input logic [SECT_W-1:0]          rd_sector,
    input logic [LOC_W-1:0]           rd_loc,
    input logic                       ins,
    input logic                       push_req,
    input logic                       fifo_full,
    input logic                       ovf_flag,
    input logic                       fix_req,
    input logic                       scrub_en,
    input logic [$clog2(DEPTH+1)-1:0] level
);
    // R8
    pin_means_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_pin |-> rd_valid);
    // R9
    reassert_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_pin && ins) |=> !err_pin);
    // R10
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && fifo_full) |=> ovf_flag);
    // R10
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level <= ($clog2(DEPTH+1))'(DEPTH));
    // R2
    head_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_sector) && $stable(rd_loc)));
    // R3
    fix_needs_scrub_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fix_req |-> $past(scrub_en));
endmodule

bind softerr_report_queue softerr_report_queue_chk #(
    .DEPTH(DEPTH), .SECT_W(SECT_W), .LOC_W(LOC_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .err_pin(err_pin), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_sector(rd_sector), .rd_loc(rd_loc), .ins(ins),
    .push_req(push_req), .fifo_full(fifo_full), .ovf_flag(ovf_flag),
    .fix_req(fix_req), .scrub_en(scrub_en), .level(level)
);

// File: tb/softerr_report_queue_bench.sv
module softerr_report_queue_bench;
    localparam int NS = 8, LW = 12, PW = 12, DP = 16, SW = 3;

    logic          clk = 1'b0, rst_n = 1'b0, scrub_en = 1'b1;
    logic [PW-1:0] period = '0;
    logic          rpt_valid = 1'b0, rpt_uncorr = 1'b0, rd_ready = 1'b0;
    logic [SW-1:0] rpt_sector = '0;
    logic [LW-1:0] rpt_loc = '0;
    logic [NS-1:0] hold_req = '0, reload_done = '0;
    logic          rd_valid, rd_uncorr, rd_repeat, ovf_flag, err_pin, fix_req;
    logic [SW-1:0] rd_sector, fix_sector;
    logic [LW-1:0] rd_loc;
    int            n_chk = 0, n_bad = 0;
    bit            done = 1'b0;

    softerr_report_queue #(.N_SECTORS(NS), .LOC_W(LW), .PER_W(PW), .DEPTH(DP)) u_softerr_report_queue (
        .clk(clk), .rst_n(rst_n), .scrub_en(scrub_en), .reinsert_period(period),
        .rpt_valid(rpt_valid), .rpt_sector(rpt_sector), .rpt_uncorr(rpt_uncorr),
        .rpt_loc(rpt_loc), .hold_req(hold_req), .reload_done(reload_done),
        .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_sector(rd_sector),
        .rd_uncorr(rd_uncorr), .rd_repeat(rd_repeat), .rd_loc(rd_loc),
        .ovf_flag(ovf_flag), .err_pin(err_pin), .fix_req(fix_req),
        .fix_sector(fix_sector)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic send(input logic [SW-1:0] s, input logic u, input logic [LW-1:0] l);
        rpt_valid = 1'b1; rpt_sector = s; rpt_uncorr = u; rpt_loc = l;
        tick();
        rpt_valid = 1'b0;
    endtask

    task automatic pop();
        rd_ready = 1'b1;
        tick();
        rd_ready = 1'b0;
    endtask

    task automatic done_pulse(input logic [NS-1:0] m);
        reload_done = m;
        tick();
        reload_done = '0;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 rd_valid", rd_valid, 0);
        chk("R1 err_pin", err_pin, 0);
        chk("R1 ovf_flag", ovf_flag, 0);
        chk("R1 fix_req", fix_req, 0);

        // R2/R3/R8 sweep all sectors, scrubbing on, correctable
        for (int s = 0; s < NS; s++) begin
            send(SW'(s), 1'b0, LW'(s * 3 + 1));
            chk("R3 fix_req", fix_req, 1);
            chk("R3 fix_sector", fix_sector, s);
            chk("R8 pin up", err_pin, 1);
            chk("R2 head sector", rd_sector, s);
            chk("R2 head loc", rd_loc, s * 3 + 1);
            chk("R2 repeat", rd_repeat, 0);
            tick();
            chk("R3 one pulse", fix_req, 0);
            for (int k = 0; k < 4; k++) tick();
            chk("R2 persists", rd_valid, 1);
            chk("R2 persists loc", rd_loc, s * 3 + 1);
            pop();
            chk("R2 drained", rd_valid, 0);
            chk("R8 pin down", err_pin, 0);
        end

        // R9 insertion while pin high
        send(3'd1, 1'b0, 12'h0A1);
        chk("R9 pin high", err_pin, 1);
        send(3'd2, 1'b0, 12'h0B2);
        chk("R9 pin gap", err_pin, 0);
        tick();
        chk("R9 pin back", err_pin, 1);
        pop();
        chk("R2 order", rd_loc, 12'h0B2);
        chk("R8 pin stays", err_pin, 1);
        pop();
        chk("R8 pin drop", err_pin, 0);

        // R7 hold masks reports
        hold_req = 8'h08; reload_done = 8'h08;
        tick();
        hold_req = '0; reload_done = '0;
        send(3'd3, 1'b0, 12'h033);
        chk("R7 masked queue", rd_valid, 0);
        chk("R7 masked fix", fix_req, 0);
        done_pulse(8'h08);
        send(3'd3, 1'b0, 12'h034);
        chk("R7 released", rd_valid, 1);
        chk("R7 released loc", rd_loc, 12'h034);
        pop();

        // R4 scrubbing off disables sector after first report
        scrub_en = 1'b0;
        for (int s = 0; s < NS; s++) begin
            send(SW'(s), 1'b0, LW'(s + 16));
            chk("R3 no fix when off", fix_req, 0);
        end
        for (int s = 0; s < NS; s++) send(SW'(s), s[0], LW'(s + 200));
        for (int s = 0; s < NS; s++) begin
            chk("R4 first only", rd_loc, s + 16);
            pop();
        end
        chk("R4 later ignored", rd_valid, 0);
        // R6 reload re-enables detection
        done_pulse(8'h01);
        send(3'd0, 1'b0, 12'h063);
        chk("R6 re-enabled", rd_valid, 1);
        chk("R6 re-enabled loc", rd_loc, 12'h063);
        pop();
        done_pulse(8'hFF);
        scrub_en = 1'b1;

        // R10 overflow: drop newest, sticky until read
        for (int i = 0; i <= DP; i++) send(SW'(i % NS), 1'b0, LW'(i));
        chk("R10 ovf set", ovf_flag, 1);
        pop();
        chk("R10 ovf clear", ovf_flag, 0);
        for (int i = 1; i < DP; i++) begin
            chk("R10 kept order", rd_loc, i);
            pop();
        end
        chk("R10 newest dropped", rd_valid, 0);

        // R5 period 0 disables copies
        period = '0;
        send(3'd6, 1'b1, 12'h066);
        pop();
        for (int k = 0; k < 50; k++) tick();
        chk("R5 period0 none", rd_valid, 0);
        done_pulse(8'h40);

        // R5 periodic copies, R6 stop on reload
        period = 12'd20;
        send(3'd5, 1'b1, 12'h155);
        chk("R5 original", rd_repeat, 0);
        chk("R5 original uc", rd_uncorr, 1);
        pop();
        for (int k = 0; k < 19; k++) tick();
        chk("R5 not early", rd_valid, 0);
        tick();
        chk("R5 copy due", rd_valid, 1);
        chk("R5 copy flag", rd_repeat, 1);
        chk("R5 copy sector", rd_sector, 5);
        chk("R5 copy loc", rd_loc, 12'h155);
        chk("R8 copy pin", err_pin, 1);
        pop();
        for (int k = 0; k < 18; k++) tick();
        chk("R5 second not early", rd_valid, 0);
        tick();
        chk("R5 second copy", rd_repeat, 1);
        pop();
        done_pulse(8'h20);
        for (int k = 0; k < 60; k++) tick();
        chk("R6 copies stopped", rd_valid, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule